// File: doc/BRIEF.md
# Secured Configuration Store

This block keeps the configuration image of a small programmable logic device and a short user signature, and it decides which programmer commands are honoured. An external programmer sends one command per cycle over a valid/ready handshake. The commands write and verify image words, write and read signature bytes, issue a register preload, set the security bit, or bulk-erase the store. Every accepted command returns exactly one response on the following cycle. The response carries read data and a denied flag.

The security bit is one-way. From the command after the one that sets it, verify reads return zeros and are flagged as denied. Preload requests produce no strobe. Image and signature writes are dropped. Signature reads still succeed. Only a bulk erase clears the bit, and the erase also clears the image and the signature. The full image is presented continuously on `cfg_bits` for the logic it configures. The image, the signature and the security bit are non-volatile: reset does not touch them, so a reset cannot unlock the store.

Top module: `cfg_vault`

## Requirements
- R1: `cmd_ready` is 0 while `rst_n` is low and 1 from the first clock after release. A command is accepted when `cmd_valid` and `cmd_ready` are both high. Each accepted command gives `rsp_valid` high for exactly the next cycle. A cycle without acceptance gives no response.
- R2: Opcode 0 (image write) stores `cmd_wdata` into word `cmd_addr` when unlocked. The word appears on `cfg_bits[cmd_addr*WORD_W +: WORD_W]` one cycle after acceptance, and no other word changes.
- R3: Opcode 1 (verify) returns the addressed image word on `rsp_data` with `rsp_denied` low when unlocked.
- R4: Opcode 5 (lock) sets `locked` one cycle after acceptance, so the very next command sees the locked state. `locked` then stays high until an erase.
- R5: While locked, verify returns `rsp_data` of all zeros with `rsp_denied` high.
- R6: Opcode 4 (preload) raises `pre_stb` for one cycle alongside its response, with `pre_data` equal to `cmd_wdata`, when unlocked. While locked, it gives no strobe and a denied response.
- R7: While locked, opcode 0 and opcode 2 (signature write) are denied and change neither `cfg_bits` nor any signature byte.
- R8: Opcode 3 (signature read) returns signature byte `cmd_addr[2:0]` in the low 8 bits of `rsp_data`, with the upper bits zero. It is never denied, whether locked or not. Opcode 2 stores `cmd_wdata[7:0]` into that byte when unlocked.
- R9: Opcode 6 (bulk erase) is never denied. It clears every image word, every signature byte and `locked`, all visible one cycle after acceptance.
- R10: Opcode 7 is reserved. It is always answered with `rsp_denied` high and zero data, and it changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset of the handshake and response logic |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Block can accept a command |
| cmd_op | input | 3 | Opcode (0 write, 1 verify, 2 sig write, 3 sig read, 4 preload, 5 lock, 6 erase, 7 reserved) |
| cmd_addr | input | $clog2(FUSE_WORDS) | Image word index; low 3 bits select the signature byte |
| cmd_wdata | input | WORD_W | Write or preload data |
| rsp_valid | output | 1 | Response for the command accepted one cycle earlier |
| rsp_data | output | WORD_W | Read data, zero when denied or when nothing is read |
| rsp_denied | output | 1 | Command refused |
| pre_stb | output | 1 | Preload request pulse |
| pre_data | output | WORD_W | Preload value |
| locked | output | 1 | Security bit |
| cfg_bits | output | FUSE_WORDS*WORD_W | Active configuration image |

## Verification
The properties assume that the command inputs are stable and known whenever `cmd_valid` is high. They also assume that opcodes and addresses are only judged in cycles where a command is accepted. The stimulus changes inputs only on the falling clock edge and holds them for the whole cycle. It drops `cmd_valid` between bursts. It issues a bulk erase before relying on any stored contents, because the non-volatile state is undefined after power-up.

// File: rtl/cfg_vault.sv
module cfg_vault #(
  parameter int FUSE_WORDS = 32,
  parameter int WORD_W     = 8,
  parameter int SIG_BYTES  = 8
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         cmd_valid,
  output logic                         cmd_ready,
  input  logic [2:0]                   cmd_op,
  input  logic [$clog2(FUSE_WORDS)-1:0] cmd_addr,
  input  logic [WORD_W-1:0]            cmd_wdata,
  output logic                         rsp_valid,
  output logic [WORD_W-1:0]            rsp_data,
  output logic                         rsp_denied,
  output logic                         pre_stb,
  output logic [WORD_W-1:0]            pre_data,
  output logic                         locked,
  output logic [FUSE_WORDS*WORD_W-1:0] cfg_bits
);
  localparam int IMG_W  = FUSE_WORDS * WORD_W;
  localparam int SIG_W  = SIG_BYTES * 8;
  localparam int SIG_AW = $clog2(SIG_BYTES);

  localparam logic [2:0] OP_WR     = 3'd0;
  localparam logic [2:0] OP_VERIFY = 3'd1;
  localparam logic [2:0] OP_SIGWR  = 3'd2;
  localparam logic [2:0] OP_SIGRD  = 3'd3;
  localparam logic [2:0] OP_PRE    = 3'd4;
  localparam logic [2:0] OP_LOCK   = 3'd5;
  localparam logic [2:0] OP_ERASE  = 3'd6;
  localparam logic [2:0] OP_RSV    = 3'd7;

  logic [IMG_W-1:0]  img_q;
  logic [SIG_W-1:0]  sig_q;
  logic              lock_q;
  logic              ready_q;
  logic [SIG_AW-1:0] sig_idx;
  logic [WORD_W-1:0] img_word, sig_word, rd_word;
  logic              take, guarded, deny;

  assign take     = cmd_valid && ready_q;
  assign sig_idx  = cmd_addr[SIG_AW-1:0];
  assign img_word = img_q[cmd_addr*WORD_W +: WORD_W];
  assign sig_word = WORD_W'(sig_q[sig_idx*8 +: 8]);
  assign guarded  = lock_q && (cmd_op == OP_WR || cmd_op == OP_VERIFY ||
                               cmd_op == OP_SIGWR || cmd_op == OP_PRE);
  assign deny     = guarded || (cmd_op == OP_RSV);
  assign rd_word  = (cmd_op == OP_VERIFY) ? img_word :
                    (cmd_op == OP_SIGRD)  ? sig_word : '0;

  assign cmd_ready = ready_q;
  assign locked    = lock_q;
  assign cfg_bits  = img_q;

  always_ff @(posedge clk) begin
    if (take) begin
      case (cmd_op)
        OP_WR:    if (!lock_q) img_q[cmd_addr*WORD_W +: WORD_W] <= cmd_wdata;
        OP_SIGWR: if (!lock_q) sig_q[sig_idx*8 +: 8] <= cmd_wdata[7:0];
        OP_LOCK:  lock_q <= 1'b1;
        OP_ERASE: begin
          img_q  <= '0;
          sig_q  <= '0;
          lock_q <= 1'b0;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ready_q    <= 1'b0;
      rsp_valid  <= 1'b0;
      rsp_data   <= '0;
      rsp_denied <= 1'b0;
      pre_stb    <= 1'b0;
      pre_data   <= '0;
    end else begin
      ready_q    <= 1'b1;
      rsp_valid  <= take;
      rsp_denied <= take && deny;
      rsp_data   <= (take && !deny) ? rd_word : '0;
      pre_stb    <= take && (cmd_op == OP_PRE) && !lock_q;
      if (take && (cmd_op == OP_PRE) && !lock_q) pre_data <= cmd_wdata;
    end
  end
endmodule

module cfg_vault_chk #(
  parameter int WORD_W = 8,
  parameter int IMG_W  = 256
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cmd_valid,
  input logic              cmd_ready,
  input logic [2:0]        cmd_op,
  input logic              rsp_valid,
  input logic [WORD_W-1:0] rsp_data,
  input logic              rsp_denied,
  input logic              pre_stb,
  input logic              locked,
  input logic [IMG_W-1:0]  cfg_bits
);
  logic acc;
  assign acc = cmd_valid && cmd_ready;

  assert_rsp_follows_R1: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> rsp_valid);
  assert_no_spurious_rsp_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !acc |=> !rsp_valid);
  assert_lock_sets_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && cmd_op == 3'd5) |=> locked);
  assert_lock_sticks_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (locked && !(acc && cmd_op == 3'd6)) |=> locked);
  assert_locked_verify_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && cmd_op == 3'd1 && locked) |=> (rsp_denied && rsp_data == '0));
  assert_locked_preload_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && cmd_op == 3'd4 && locked) |=> (!pre_stb && rsp_denied));
  assert_stb_with_rsp_R6: assert property (@(posedge clk) disable iff (!rst_n)
    pre_stb |-> rsp_valid);
  assert_image_frozen_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (locked && !(acc && cmd_op == 3'd6)) |=> $stable(cfg_bits));
  assert_sig_read_open_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && cmd_op == 3'd3) |=> !rsp_denied);
  assert_erase_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && cmd_op == 3'd6) |=> (!locked && cfg_bits == '0 && !rsp_denied));
  assert_reserved_denied_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && cmd_op == 3'd7) |=> (rsp_denied && rsp_data == '0));
endmodule

bind cfg_vault cfg_vault_chk #(.WORD_W(WORD_W), .IMG_W(IMG_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
  .cmd_op(cmd_op), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
  .rsp_denied(rsp_denied), .pre_stb(pre_stb), .locked(locked),
  .cfg_bits(cfg_bits)
);

// File: tb/cfg_vault_test.sv
module cfg_vault_test;
  localparam int NW = 32;
  localparam int WW = 8;
  localparam int AW = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_valid = 1'b0;
  logic cmd_ready;
  logic [2:0] cmd_op = '0;
  logic [AW-1:0] cmd_addr = '0;
  logic [WW-1:0] cmd_wdata = '0;
  logic rsp_valid, rsp_denied, pre_stb, locked;
  logic [WW-1:0] rsp_data, pre_data;
  logic [NW*WW-1:0] cfg_bits;

  int checks = 0;
  int errors = 0;

  logic [WW-1:0] fuse_m [NW];
  logic [7:0]    sig_m  [8];
  logic          lock_m = 1'b0;

  logic [WW-1:0] q_data [$];
  logic          q_den  [$];
  logic          q_pst  [$];
  logic [WW-1:0] q_pd   [$];
  string         q_tag  [$];

  cfg_vault uut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .rsp_denied(rsp_denied),
    .pre_stb(pre_stb), .pre_data(pre_data), .locked(locked), .cfg_bits(cfg_bits)
  );

  always #5 clk = ~clk;

  task automatic chk(input string tag, input logic [NW*WW-1:0] act, input logic [NW*WW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [NW*WW-1:0] img_model();
    logic [NW*WW-1:0] v = '0;
    for (int i = 0; i < NW; i++) v[i*WW +: WW] = fuse_m[i];
    return v;
  endfunction

  task automatic send(input logic [2:0] op, input logic [AW-1:0] a, input logic [WW-1:0] d, input string tag);
    logic [WW-1:0] ed = '0;
    logic den = 1'b0;
    logic pst = 1'b0;
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_addr = a; cmd_wdata = d;
    case (op)
      3'd0: if (lock_m) den = 1'b1; else fuse_m[a] = d;
      3'd1: if (lock_m) den = 1'b1; else ed = fuse_m[a];
      3'd2: if (lock_m) den = 1'b1; else sig_m[a[2:0]] = d;
      3'd3: ed = WW'(sig_m[a[2:0]]);
      3'd4: if (lock_m) den = 1'b1; else pst = 1'b1;
      3'd5: lock_m = 1'b1;
      3'd6: begin
        lock_m = 1'b0;
        for (int i = 0; i < NW; i++) fuse_m[i] = '0;
        for (int i = 0; i < 8; i++) sig_m[i] = '0;
      end
      default: den = 1'b1;
    endcase
    q_data.push_back(ed); q_den.push_back(den); q_pst.push_back(pst);
    q_pd.push_back(d); q_tag.push_back(tag);
  endtask

  task automatic idle();
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      if (q_tag.size() == 0) begin
        chk("R1 unexpected response", 1, 0);
      end else begin
        logic [WW-1:0] ed, pd;
        logic den, pst;
        string t;
        ed = q_data.pop_front(); den = q_den.pop_front(); pst = q_pst.pop_front();
        pd = q_pd.pop_front(); t = q_tag.pop_front();
        chk({t, " data"}, rsp_data, ed);
        chk({t, " denied"}, rsp_denied, den);
        chk({t, " pre_stb"}, pre_stb, pst);
        if (pst) chk({t, " pre_data"}, pre_data, pd);
      end
    end else if (rst_n && pre_stb) begin
      chk("R6 strobe without response", 1, 0);
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 ready low in reset", cmd_ready, 0);
    chk("R1 no response in reset", rsp_valid, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 ready after reset", cmd_ready, 1);

    send(3'd6, 0, 0, "R9 initial erase");
    idle();
    chk("R9 unlocked after erase", locked, 0);
    chk("R9 image clear", cfg_bits, 0);

    send(3'd0, 0, 8'hA5, "R2 write w0");
    send(3'd0, 5, 8'h3C, "R2 write w5");
    send(3'd0, 31, 8'hFF, "R2 write w31");
    idle();
    chk("R2 image after writes", cfg_bits, img_model());
    send(3'd1, 0, 0, "R3 verify w0");
    send(3'd1, 5, 0, "R3 verify w5");
    send(3'd1, 31, 0, "R3 verify w31");
    send(3'd1, 7, 0, "R3 verify blank w7");
    idle();

    for (int i = 0; i < 8; i++) send(3'd2, AW'(i), WW'(8'h10 + i * 8'h11), "R8 sig write");
    for (int i = 0; i < 8; i++) send(3'd3, AW'(i), 0, "R8 sig read unlocked");
    send(3'd3, AW'(8 + 2), 0, "R8 sig index from low bits");
    idle();

    send(3'd4, 0, 8'h5A, "R6 preload unlocked");
    send(3'd4, 0, 8'hC3, "R6 preload back to back");
    idle();
    idle();
    chk("R1 quiet when idle", rsp_valid, 0);

    send(3'd5, 0, 0, "R4 lock");
    send(3'd1, 5, 0, "R5 verify right after lock");
    idle();
    chk("R4 locked flag", locked, 1);
    send(3'd4, 0, 8'h77, "R6 preload locked");
    send(3'd0, 5, 8'h00, "R7 write locked");
    send(3'd0, 9, 8'hEE, "R7 write locked blank");
    send(3'd2, 1, 8'h99, "R7 sig write locked");
    send(3'd3, 1, 0, "R8 sig read locked");
    send(3'd3, 7, 0, "R8 sig read locked top");
    send(3'd1, 0, 0, "R5 verify locked w0");
    send(3'd5, 0, 0, "R4 relock");
    send(3'd7, 3, 8'h12, "R10 reserved locked");
    idle();
    chk("R7 image unchanged", cfg_bits, img_model());
    chk("R4 still locked", locked, 1);

    send(3'd6, 0, 0, "R9 erase locked");
    idle();
    chk("R9 lock cleared", locked, 0);
    chk("R9 image cleared", cfg_bits, 0);
    send(3'd3, 3, 0, "R9 sig cleared");
    send(3'd1, 0, 0, "R9 verify after erase");
    send(3'd0, 2, 8'h42, "R2 write after erase");
    send(3'd7, 2, 8'h13, "R10 reserved unlocked");
    send(3'd1, 2, 0, "R10 no state change");
    idle();
    chk("R10 image intact", cfg_bits, img_model());
    chk("R10 lock intact", locked, 0);
    idle();
    chk("R1 all responses seen", q_tag.size(), 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule